// File: doc/BRIEF.md
# Reset-Time Program Boot Sequencer

This block decides, from three configuration pins, how on-chip program memory gets its contents once reset is released, and holds the processor's run enable low until that is done. In byte-memory boot mode it presets a small set of transfer registers during reset. It then streams bytes out of an external byte-wide memory and packs each group of three into a 24-bit program word. The words are written into on-chip program memory from address 0 upward. After the last of the 32 words has gone in, it releases execution, which starts at program address 0.

In host-port boot mode the block does no reads of its own. A host loads program memory through a separate port, as many locations as it likes. The block watches those writes and releases execution once the host writes program location 0. Every other pin setting needs no load, and execution is released right after reset.

Top module: `boot_loader`

## Requirements
- R1: The pins are decoded as follows. mode_a=0 selects byte-memory boot. {mode_c,mode_b,mode_a}=3'b101 selects host-port boot. Any other setting selects no boot, and run goes high in the first cycle after reset release.
- R2: The mode pins are sampled only while rst is high, and the value present at the last reset cycle is kept. Changing the pins after release does not change the boot mode in progress.
- R3: While rst is high with byte-memory boot selected, these outputs read 0: dma_dir, dma_page, dma_type (0 = 24-bit program words), bm_addr and pm_addr. dma_count reads 32, dma_hold reads 1, run reads 0, and pm_we and bm_rd_en read 0.
- R4: In byte-memory boot the block issues exactly 96 byte reads. They start at byte address 0, the address rises by one per read, and data returns one cycle after bm_rd_en.
- R5: Each program word is three consecutive bytes, with the first byte read in bits 23:16 and the last byte read in bits 7:0. Word k is written to program address k, for k = 0..31, in increasing order.
- R6: During a word write, dma_count equals 32 minus the number of earlier word writes. It drops by exactly one at the clock edge that ends each write cycle and never changes otherwise.
- R7: In byte-memory boot, run stays 0 and dma_hold stays 1 until the 32nd word is written. In the cycle after that write, dma_count reads 0, boot_done and run read 1, and dma_hold reads 0.
- R8: In host-port boot, no byte read is issued and run stays 0 through host writes to any non-zero address. run goes to 1 in the cycle after the host writes program address 0.
- R9: Once run is 1, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode pins are sampled while high |
| mode_a | input | 1 | Boot configuration pin A |
| mode_b | input | 1 | Boot configuration pin B |
| mode_c | input | 1 | Boot configuration pin C |
| bm_rd_en | output | 1 | Byte memory read strobe |
| bm_addr | output | 14 | Byte memory address (external address register) |
| bm_rd_data | input | 8 | Byte memory read data, valid one cycle after the strobe |
| pm_we | output | 1 | Program memory write strobe |
| pm_addr | output | 14 | Program memory write address (internal address register) |
| pm_wdata | output | 24 | Packed program word |
| host_we | input | 1 | Host program-memory write seen on the host port |
| host_addr | input | 14 | Program address of the host write |
| run | output | 1 | Execution enable, 1 = processor may run |
| boot_done | output | 1 | Load complete |
| dma_dir | output | 1 | Transfer direction register |
| dma_page | output | 8 | Byte memory page register |
| dma_type | output | 2 | Transfer type register |
| dma_count | output | 6 | Remaining word count |
| dma_hold | output | 1 | Execution hold-off bit |

## Verification
The bench sweeps all eight pin settings and checks the reset presets and the mode each one selects. Byte memory is filled with an affine function of the address, so a swapped byte order, a skipped or repeated address, or a word written to the wrong location each give a different packed value. One byte boot run flips the pins to the host setting just after release and fakes a host write to address 0; this tells real latching apart from live decoding of the pins. The host runs write non-zero addresses first, which tells a release keyed to address 0 apart from a release on any write.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    BOOT_NONE = 2'd0,
    BOOT_BYTE = 2'd1,
    BOOT_HOST = 2'd2
  } boot_kind_e;

  function automatic boot_kind_e decode_mode(input logic pc, input logic pb, input logic pa);
    if (!pa)
      return BOOT_BYTE;
    else if (pc && !pb)
      return BOOT_HOST;
    else
      return BOOT_NONE;
  endfunction

endpackage

// File: rtl/boot_mode_latch.sv
module boot_mode_latch
  import boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  boot_kind_e pins_kind,
  output boot_kind_e kind
);

  always_ff @(posedge clk) begin
    if (rst)
      kind <= pins_kind;
  end

  // R2: the latched mode never moves once reset is gone
  a_r2_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    !$rose(rst) |=> $stable(kind));

endmodule

// File: rtl/boot_fetch.sv
module boot_fetch #(
  parameter int ADDR_W = 14,
  parameter int TOTAL  = 96
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_valid
);

  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [CNT_W-1:0] issued;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en    <= 1'b0;
      addr     <= '0;
      issued   <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (en && issued < CNT_W'(TOTAL)) begin
        rd_en  <= 1'b1;
        addr   <= ADDR_W'(issued);
        issued <= issued + 1'b1;
      end else begin
        rd_en  <= 1'b0;
      end
    end
  end

  // R4: back-to-back reads walk the address up by one
  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> addr == $past(addr) + 1'b1);

  // R4: never more reads than the load needs
  a_r4_read_budget: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> issued <= CNT_W'(TOTAL));

endmodule

// File: rtl/boot_packer.sv
module boot_packer #(
  parameter int BYTE_W = 8,
  parameter int BPW    = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  byte_valid,
  input  logic [BYTE_W-1:0]     byte_in,
  output logic                  word_valid,
  output logic [BYTE_W*BPW-1:0] word_out
);

  localparam int WORD_W = BYTE_W * BPW;
  localparam int IDX_W  = (BPW > 1) ? $clog2(BPW) : 1;

  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] acc_next;
  logic [IDX_W-1:0]  idx;

  generate
    if (BPW > 1) begin : g_shift
      assign acc_next = {acc[WORD_W-BYTE_W-1:0], byte_in};
    end else begin : g_single
      assign acc_next = byte_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      idx        <= '0;
      word_valid <= 1'b0;
      word_out   <= '0;
    end else begin
      word_valid <= 1'b0;
      if (byte_valid) begin
        acc <= acc_next;
        if (idx == IDX_W'(BPW - 1)) begin
          idx        <= '0;
          word_valid <= 1'b1;
          word_out   <= acc_next;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  generate
    if (BPW > 1) begin : g_chk
      // R5: a word needs several bytes, so writes never come back to back
      a_r5_word_spacing: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);
    end
  endgenerate

endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_pkg::*;
#(
  parameter int PM_AW     = 14,
  parameter int WORDS     = 32,
  parameter int PAGE_W    = 8,
  parameter int CNT_W     = $clog2(WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  boot_kind_e        pins_kind,
  input  boot_kind_e        kind,
  input  logic              word_valid,
  input  logic              host_we,
  input  logic [PM_AW-1:0]  host_addr,
  output logic [PM_AW-1:0]  int_addr,
  output logic [CNT_W-1:0]  count,
  output logic              hold,
  output logic              run,
  output logic              done,
  output logic              dir,
  output logic [PAGE_W-1:0] page,
  output logic [1:0]        xfer_type
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= (pins_kind == BOOT_BYTE) ? CNT_W'(WORDS) : '0;
      hold      <= (pins_kind != BOOT_NONE);
      int_addr  <= '0;
      run       <= 1'b0;
      done      <= 1'b0;
      dir       <= 1'b0;
      page      <= '0;
      xfer_type <= 2'd0;
    end else begin
      unique case (kind)
        BOOT_BYTE: begin
          if (word_valid && count != '0) begin
            int_addr <= int_addr + 1'b1;
            count    <= count - 1'b1;
            if (count == CNT_W'(1)) begin
              hold <= 1'b0;
              run  <= 1'b1;
              done <= 1'b1;
            end
          end
        end
        BOOT_HOST: begin
          if (hold && host_we && host_addr == '0) begin
            hold <= 1'b0;
            run  <= 1'b1;
            done <= 1'b1;
          end
        end
        default: begin
          hold <= 1'b0;
          run  <= 1'b1;
        end
      endcase
    end
  end

  // R6: the count only ever steps down by one, after a word write
  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> ($past(word_valid) && count == $past(count) - 1'b1));

  // R7: the byte-mode release happens exactly when the count hits zero
  a_r7_release_at_zero: assert property (@(posedge clk) disable iff (rst)
    ($rose(run) && kind == BOOT_BYTE) |-> count == '0);

endmodule

// File: rtl/boot_loader.sv
module boot_loader
  import boot_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int BPW    = 3,
  parameter int WORDS  = 32,
  parameter int EXT_AW = 14,
  parameter int PM_AW  = 14,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = $clog2(WORDS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mode_a,
  input  logic                  mode_b,
  input  logic                  mode_c,
  output logic                  bm_rd_en,
  output logic [EXT_AW-1:0]     bm_addr,
  input  logic [BYTE_W-1:0]     bm_rd_data,
  output logic                  pm_we,
  output logic [PM_AW-1:0]      pm_addr,
  output logic [BYTE_W*BPW-1:0] pm_wdata,
  input  logic                  host_we,
  input  logic [PM_AW-1:0]      host_addr,
  output logic                  run,
  output logic                  boot_done,
  output logic                  dma_dir,
  output logic [PAGE_W-1:0]     dma_page,
  output logic [1:0]            dma_type,
  output logic [CNT_W-1:0]      dma_count,
  output logic                  dma_hold
);

  localparam int TOTAL_BYTES = WORDS * BPW;

  boot_kind_e pins_kind;
  boot_kind_e kind;
  logic       rd_valid;

  assign pins_kind = decode_mode(mode_c, mode_b, mode_a);

  boot_mode_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .pins_kind (pins_kind),
    .kind      (kind)
  );

  boot_fetch #(.ADDR_W(EXT_AW), .TOTAL(TOTAL_BYTES)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .en       (kind == BOOT_BYTE),
    .rd_en    (bm_rd_en),
    .addr     (bm_addr),
    .rd_valid (rd_valid)
  );

  boot_packer #(.BYTE_W(BYTE_W), .BPW(BPW)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (rd_valid),
    .byte_in    (bm_rd_data),
    .word_valid (pm_we),
    .word_out   (pm_wdata)
  );

  boot_ctrl #(.PM_AW(PM_AW), .WORDS(WORDS), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pins_kind  (pins_kind),
    .kind       (kind),
    .word_valid (pm_we),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .int_addr   (pm_addr),
    .count      (dma_count),
    .hold       (dma_hold),
    .run        (run),
    .done       (boot_done),
    .dir        (dma_dir),
    .page       (dma_page),
    .xfer_type  (dma_type)
  );

  // R7: running and holding are mutually exclusive
  a_r7_run_excludes_hold: assert property (@(posedge clk) disable iff (rst)
    run |-> !dma_hold);

  // R9: run is sticky until reset
  a_r9_run_sticky: assert property (@(posedge clk) disable iff (rst)
    run |=> run);

  // R8: host-mode release follows a host write to address 0
  a_r8_host_release: assert property (@(posedge clk) disable iff (rst)
    ($rose(run) && kind == BOOT_HOST) |-> $past(host_we && host_addr == '0));

  // R8: no byte traffic in host mode
  a_r8_host_no_reads: assert property (@(posedge clk) disable iff (rst)
    (kind == BOOT_HOST) |-> !bm_rd_en);

  // R1: program writes only come from byte-memory boot
  a_r1_writes_only_byte: assert property (@(posedge clk) disable iff (rst)
    pm_we |-> kind == BOOT_BYTE);

endmodule

// File: tb/boot_loader_test.sv
module boot_loader_test;

  localparam int WORDS = 32;
  localparam int BPW   = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_a = 1'b0, mode_b = 1'b0, mode_c = 1'b0;
  logic        bm_rd_en;
  logic [13:0] bm_addr;
  logic [7:0]  bm_rd_data = '0;
  logic        pm_we;
  logic [13:0] pm_addr;
  logic [23:0] pm_wdata;
  logic        host_we = 1'b0;
  logic [13:0] host_addr = '0;
  logic        run, boot_done, dma_dir, dma_hold;
  logic [7:0]  dma_page;
  logic [1:0]  dma_type;
  logic [5:0]  dma_count;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  boot_loader uut (
    .clk(clk), .rst(rst), .mode_a(mode_a), .mode_b(mode_b), .mode_c(mode_c),
    .bm_rd_en(bm_rd_en), .bm_addr(bm_addr), .bm_rd_data(bm_rd_data),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .host_we(host_we), .host_addr(host_addr),
    .run(run), .boot_done(boot_done), .dma_dir(dma_dir), .dma_page(dma_page),
    .dma_type(dma_type), .dma_count(dma_count), .dma_hold(dma_hold)
  );

  function automatic logic [7:0] byte_at(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  always_ff @(posedge clk)
    if (bm_rd_en) bm_rd_data <= byte_at(int'(bm_addr));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [2:0] m);
    @(negedge clk);
    rst = 1'b1;
    {mode_c, mode_b, mode_a} = m;
    host_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(run == 1'b0, "R3", "run in reset", run, 0);
    chk(pm_we == 1'b0 && bm_rd_en == 1'b0, "R3", "strobes in reset", {pm_we, bm_rd_en}, 0);
    if (m[0] == 1'b0) begin
      chk(dma_count == 6'd32, "R3", "count preset", dma_count, 32);
      chk(dma_hold == 1'b1, "R3", "hold preset", dma_hold, 1);
      chk(dma_dir == 1'b0 && dma_page == 8'd0 && dma_type == 2'd0, "R3",
          "dir/page/type", {dma_dir, dma_page, dma_type}, 0);
      chk(bm_addr == 14'd0 && pm_addr == 14'd0, "R3", "addresses", {bm_addr, pm_addr}, 0);
    end
    rst = 1'b0;
  endtask

  task automatic byte_boot(input bit flip_pins);
    int reads = 0;
    int writes = 0;
    bit fin = 1'b0;
    for (int cyc = 1; cyc <= 400 && !fin; cyc++) begin
      @(negedge clk);
      if (flip_pins && cyc == 2) begin
        {mode_c, mode_b, mode_a} = 3'b101;
        host_addr = '0;
        host_we = 1'b1;
      end
      if (flip_pins && cyc == 3) host_we = 1'b0;
      if (bm_rd_en) begin
        chk(int'(bm_addr) == reads, "R4", "byte address", bm_addr, reads);
        reads++;
      end
      if (pm_we) begin
        chk(int'(pm_addr) == writes, "R5", "word address", pm_addr, writes);
        chk(pm_wdata == {byte_at(3*writes), byte_at(3*writes+1), byte_at(3*writes+2)},
            "R5", "packed word", pm_wdata,
            {byte_at(3*writes), byte_at(3*writes+1), byte_at(3*writes+2)});
        chk(int'(dma_count) == WORDS - writes, "R6", "count at write", dma_count, WORDS - writes);
        chk(run == 1'b0 && dma_hold == 1'b1, "R7", "held during load", {run, dma_hold}, 1);
        writes++;
      end else if (writes == WORDS) begin
        chk(dma_count == 6'd0, "R7", "count zero", dma_count, 0);
        chk(run == 1'b1 && boot_done == 1'b1, "R7", "release", {run, boot_done}, 3);
        chk(dma_hold == 1'b0, "R7", "hold cleared", dma_hold, 0);
        fin = 1'b1;
      end else begin
        chk(run == 1'b0, flip_pins ? "R2" : "R7", "run before load end", run, 0);
      end
    end
    chk(reads == WORDS * BPW, "R4", "read total", reads, WORDS * BPW);
    chk(writes == WORDS, "R5", "write total", writes, WORDS);
    repeat (5) begin
      @(negedge clk);
      chk(run == 1'b1, "R9", "run sticky", run, 1);
      chk(bm_rd_en == 1'b0 && pm_we == 1'b0, "R4", "no traffic after load", {bm_rd_en, pm_we}, 0);
    end
  endtask

  task automatic host_boot();
    bit any_read = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      host_we = 1'b1;
      host_addr = 14'(k * 5);
      @(negedge clk);
      host_we = 1'b0;
      if (bm_rd_en) any_read = 1'b1;
      chk(run == 1'b0, "R8", "run after non-zero write", run, 0);
    end
    @(negedge clk);
    host_we = 1'b1;
    host_addr = '0;
    chk(run == 1'b0, "R8", "run before zero write", run, 0);
    @(negedge clk);
    host_we = 1'b0;
    chk(run == 1'b1, "R8", "run after zero write", run, 1);
    chk(!any_read && !bm_rd_en, "R8", "no byte reads", any_read, 0);
    repeat (3) begin
      @(negedge clk);
      chk(run == 1'b1, "R9", "run sticky host", run, 1);
    end
  endtask

  task automatic none_boot();
    @(negedge clk);
    chk(run == 1'b1, "R1", "no-boot release", run, 1);
    chk(bm_rd_en == 1'b0 && pm_we == 1'b0, "R1", "no-boot traffic", {bm_rd_en, pm_we}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int m = 0; m < 8; m++) begin
      apply_reset(3'(m));
      if (m[0] == 0)      byte_boot(1'b0);
      else if (m == 5)    host_boot();
      else                none_boot();
    end
    apply_reset(3'b010);
    byte_boot(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule